// File: doc/BRIEF.md
# Shared Interrupt Node Request Logic

This block merges the event flags of one peripheral into a single interrupt request for a CPU core. Each event input is watched for rising edges. A rising edge sets that event's sticky status flag. Software clears a flag with a one-cycle strobe. An event may have its own interrupt enable, chosen per event at build time. An event built without one is always treated as enabled. A flag whose event is enabled is called qualified.

The node keeps one pending-request bit. Every rising edge of a qualified event sets this bit, whatever state the other flags are in. The core's vector acknowledge clears it. Hardware also clears it by itself as soon as no qualified flag is left set. A flag that stays set can therefore never hide a later event, so the node cannot lock up. The request presented to the core is the pending bit gated by the node enable. While the node is disabled the pending bit still latches, and software can poll the flags.

Top module: `irq_share_node`

## Requirements
- R1: A rising edge on `evt_i[i]` sets `flags_o[i]`, visible one cycle later. An event input held high sets its flag only once, so the flag stays clear after a software clear.
- R2: A high `flag_clr_i[i]` clears `flags_o[i]` one cycle later. If a rising edge arrives on the same event in the same cycle, the flag stays set.
- R3: A rising edge of a qualified event sets the pending bit in the next cycle. This holds even when that flag or any other flag is already set.
- R4: An event that has its own enable bit (`EVT_HAS_EN[i]=1`) with `evt_en_i[i]=0` still sets its flag, but it neither sets nor holds the pending bit.
- R5: `ack_i` clears the pending bit one cycle later, even when qualified flags remain set, unless a qualified rising edge arrives in the same cycle.
- R6: The pending bit clears one cycle after a cycle in which no qualified flag remains set (after that cycle's clears and sets).
- R7: An event built without its own enable (`EVT_HAS_EN[i]=0`) is qualified whatever the value of `evt_en_i[i]`.
- R8: `irq_o` equals the pending bit ANDed with `node_en_i`. The pending bit is set and held while `node_en_i=0`, so it shows on `irq_o` once the node is enabled.
- R9: During reset all flags, the pending bit and `irq_o` are 0.
- R10: After an acknowledge that leaves a flag set, a new qualified event on any flag raises `irq_o` again (no lock-up).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_EVT | Event inputs; a rising edge counts as an event |
| evt_en_i | input | NUM_EVT | Per-event interrupt enables; ignored for events built without one |
| node_en_i | input | 1 | Node enable; gates `irq_o` |
| flag_clr_i | input | NUM_EVT | Software flag-clear strobes |
| ack_i | input | 1 | Vector acknowledge from the core |
| flags_o | output | NUM_EVT | Event status flags |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the block with four events, and with `EVT_HAS_EN` set to 4'b0111 so that the top event has no enable of its own. With this setting, all sixteen enable patterns occur in the same run as an always-qualified event. Directed sequences cover the lock-up case, a clear and a set in the same cycle, and latching while the node is disabled. A long pseudo-random run then applies edges, clears, acknowledges and enable changes together, and checks them against an arithmetic model of the flags and the pending bit.

// File: rtl/irq_node_pkg.sv
package irq_node_pkg;

    typedef struct packed {
        logic evt_last;
        logic flag;
    } flag_state_t;

    typedef struct packed {
        logic pend;
    } pend_state_t;

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_node_pkg::*;
#(
    parameter bit HAS_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic ev_en_i,
    input  logic clr_i,
    output logic flag_o,
    output logic qrise_o,
    output logic qflag_nxt_o
);

    flag_state_t st_d, st_q;
    logic        rise;
    logic        eff_en;

    always_comb begin
        st_d          = st_q;
        eff_en        = ev_en_i | ~HAS_EN;
        rise          = evt_i & ~st_q.evt_last;
        st_d.evt_last = evt_i;
        st_d.flag     = (st_q.flag & ~clr_i) | rise;
        qrise_o       = rise & eff_en;
        qflag_nxt_o   = st_d.flag & eff_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

    // R1
    flag_rise_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i && !st_q.evt_last) |=> flag_o);

    // R2
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !(evt_i && !st_q.evt_last)) |=> !flag_o);

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_node_pkg::*;
#(
    parameter int NUM_EVT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] qrise_i,
    input  logic [NUM_EVT-1:0] qflag_nxt_i,
    input  logic               ack_i,
    output logic               pend_o
);

    pend_state_t st_d, st_q;
    logic        any_set;
    logic        any_qual;

    always_comb begin
        st_d     = st_q;
        any_set  = |qrise_i;
        any_qual = |qflag_nxt_i;
        st_d.pend = any_set | (st_q.pend & ~ack_i & any_qual);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;

    // R3
    pend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|qrise_i) |=> pend_o);

    // R5
    pend_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !(|qrise_i)) |=> !pend_o);

    // R6
    pend_auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|qflag_nxt_i) && !(|qrise_i)) |=> !pend_o);

endmodule

// File: rtl/irq_share_node.sv
module irq_share_node #(
    parameter int                 NUM_EVT    = 4,
    parameter logic [NUM_EVT-1:0] EVT_HAS_EN = 4'b0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] evt_en_i,
    input  logic               node_en_i,
    input  logic [NUM_EVT-1:0] flag_clr_i,
    input  logic               ack_i,
    output logic [NUM_EVT-1:0] flags_o,
    output logic               irq_o
);

    logic [NUM_EVT-1:0] qrise;
    logic [NUM_EVT-1:0] qflag_nxt;
    logic               pend;

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        irq_flag_cell #(
            .HAS_EN (EVT_HAS_EN[g])
        ) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_i       (evt_i[g]),
            .ev_en_i     (evt_en_i[g]),
            .clr_i       (flag_clr_i[g]),
            .flag_o      (flags_o[g]),
            .qrise_o     (qrise[g]),
            .qflag_nxt_o (qflag_nxt[g])
        );
    end

    irq_pend_ctrl #(
        .NUM_EVT (NUM_EVT)
    ) u_pend (
        .clk         (clk),
        .rst_n       (rst_n),
        .qrise_i     (qrise),
        .qflag_nxt_i (qflag_nxt),
        .ack_i       (ack_i),
        .pend_o      (pend)
    );

    assign irq_o = pend & node_en_i;

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> node_en_i);

    // R10
    irq_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (node_en_i && (|qrise)) |=> (pend && (irq_o || !node_en_i)));

endmodule

// File: tb/tb_irq_share_node.sv
module tb_irq_share_node;

    localparam int             N  = 4;
    localparam logic [N-1:0]   HE = 4'b0111;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] evt_i = '0;
    logic [N-1:0] evt_en_i = '0;
    logic         node_en_i = 1'b0;
    logic [N-1:0] flag_clr_i = '0;
    logic         ack_i = 1'b0;
    logic [N-1:0] flags_o;
    logic         irq_o;

    irq_share_node #(.NUM_EVT(N), .EVT_HAS_EN(HE)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_i      (evt_i),
        .evt_en_i   (evt_en_i),
        .node_en_i  (node_en_i),
        .flag_clr_i (flag_clr_i),
        .ack_i      (ack_i),
        .flags_o    (flags_o),
        .irq_o      (irq_o)
    );

    always #5 clk = ~clk;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 1'b0;

    logic [N-1:0] m_f = '0;
    logic [N-1:0] m_last = '0;
    logic         m_p = 1'b0;
    logic [31:0]  lfsr = 32'h1D2C_3B4A;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic [N-1:0] ev, input logic [N-1:0] en, input logic ne,
                       input logic [N-1:0] clr, input logic ak);
        logic [N-1:0] eff, rise, fnew;
        @(negedge clk);
        chk("R1 R2 flags model", {28'd0, flags_o}, {28'd0, m_f});
        chk("R3 R5 R6 R8 irq model", {31'd0, irq_o}, {31'd0, m_p & node_en_i});
        evt_i = ev; evt_en_i = en; node_en_i = ne; flag_clr_i = clr; ack_i = ak;
        eff    = en | ~HE;
        rise   = ev & ~m_last;
        fnew   = (m_f & ~clr) | rise;
        m_p    = (|(rise & eff)) | (m_p & ~ak & (|(fnew & eff)));
        m_f    = fnew;
        m_last = ev;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        chk("R9 flags in reset", {28'd0, flags_o}, 32'd0);
        chk("R9 irq in reset", {31'd0, irq_o}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 lock-up scenario
        cyc(4'b0001, 4'b1111, 1'b1, 4'b0000, 1'b0);
        cyc(4'b0000, 4'b1111, 1'b1, 4'b0000, 1'b1);
        settle();
        chk("R5 ack with flag still set", {31'd0, irq_o}, 32'd0);
        cyc(4'b0010, 4'b1111, 1'b1, 4'b0000, 1'b0);
        settle();
        chk("R10 new event after ack", {31'd0, irq_o}, 32'd1);
        chk("R10 flags", {28'd0, flags_o}, 32'h3);

        cyc(4'b0000, 4'b1111, 1'b1, 4'b1111, 1'b1);
        // R4 disabled event
        cyc(4'b0001, 4'b1110, 1'b1, 4'b0000, 1'b0);
        settle();
        chk("R4 flag set", {28'd0, flags_o}, 32'h1);
        chk("R4 no pending", {31'd0, irq_o}, 32'd0);
        // R7 event without own enable
        cyc(4'b1000, 4'b0000, 1'b1, 4'b0000, 1'b0);
        settle();
        chk("R7 always qualified", {31'd0, irq_o}, 32'd1);
        // R6 auto clear with only unqualified flag left
        cyc(4'b0000, 4'b0000, 1'b1, 4'b1000, 1'b0);
        settle();
        chk("R6 auto clear", {31'd0, irq_o}, 32'd0);
        chk("R6 unqualified flag kept", {28'd0, flags_o}, 32'h1);
        // R8 latch while disabled
        cyc(4'b0100, 4'b0100, 1'b0, 4'b0000, 1'b0);
        settle();
        chk("R8 gated off", {31'd0, irq_o}, 32'd0);
        cyc(4'b0000, 4'b0100, 1'b1, 4'b0000, 1'b0);
        settle();
        chk("R8 latched shows", {31'd0, irq_o}, 32'd1);
        // R2 clear and set same cycle
        cyc(4'b0100, 4'b0100, 1'b1, 4'b0100, 1'b0);
        settle();
        chk("R2 set wins", {28'd0, flags_o}, 32'h5);
        cyc(4'b0100, 4'b0100, 1'b1, 4'b0000, 1'b1);
        settle();
        chk("R5 ack clears", {31'd0, irq_o}, 32'd0);
        // R1 held event does not set again
        cyc(4'b0100, 4'b0100, 1'b1, 4'b0100, 1'b0);
        settle();
        chk("R1 held level no reset", {28'd0, flags_o}, 32'h1);
        // R3 own flag already set
        cyc(4'b0000, 4'b1111, 1'b1, 4'b0000, 1'b0);
        cyc(4'b0001, 4'b1111, 1'b1, 4'b0000, 1'b0);
        settle();
        chk("R3 set while own flag set", {31'd0, irq_o}, 32'd1);

        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] ev, en, clr;
            logic ne, ak;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            ev  = lfsr[3:0];
            en  = lfsr[7:4];
            ne  = (lfsr[10:8] != 3'd0);
            clr = lfsr[14:11] & lfsr[18:15];
            ak  = (lfsr[21:19] == 3'd5);
            cyc(ev, en, ne, clr, ak);
        end
        cyc('0, '0, 1'b1, '0, 1'b0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule